// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O SRAM Target

This block is a synthesizable memory target for a separate-I/O, burst-of-four, double-data-rate memory protocol. It acts as the self-checking partner of a memory controller. A read select, a write select and a burst base address are sampled on each rising edge of the main clock. Write data enters on two input lanes, and read data leaves on two output lanes. The rise lane carries the beat of the rising edge and the fall lane carries the beat of the complementary edge, so each clock cycle moves two 18-bit beats.

The storage depth is set by a parameter. Each address selects a group of four words, and the two low bits of the word index give the burst position. A write stores two beats on each of the two rises that follow its command. Each beat carries its own active-low byte-write pair. A read drives two beats on each of the same two following rises and raises an output-enable flag while it does so. When the flag is low, the data lanes stand for a high-impedance bus and are held at zero. A command of the same type on the rise straight after an accepted one breaks the protocol, and the block drops it without any trace.

Top module: `sio_burst4_sram`

## Requirements
- R1: While reset is asserted and after it is released with no command issued, `rq_oe_o` is 0 and both read lanes are 0.
- R2: A rise with both selects high (1) starts nothing: no output is driven and no word in the array changes.
- R3: A read accepted on rise t drives `rq_oe_o` high after rises t+1 and t+2 only, carrying burst words 0/1 after t+1 and words 2/3 after t+2.
- R4: A write accepted on rise t stores the lane data sampled on rise t+1 into burst words 0/1 and the lane data sampled on rise t+2 into burst words 2/3.
- R5: Word index is {address, position}. Positions run 00, 01, 10, 11 in burst order. The rise lane always carries the even position (00, 10) and the fall lane the odd one.
- R6: Each beat has an active-low 2-bit byte-write field. Bit 0 low writes bits 8:0 and bit 1 low writes bits 17:9. With both bits low the whole word is written. With both high the beat leaves the word untouched.
- R7: A read select low on the rise right after an accepted read is ignored. A read select low one rise later again is accepted.
- R8: A write select low on the rise right after an accepted write is ignored, and neither its address nor any later lane data reaches that address.
- R9: A read returns the array contents as they stand before the rise that drives its first beats. Beats captured on that rise or later are not seen, even when a write to the same address was issued on the same rise.
- R10: Whenever `rq_oe_o` is low, both read lanes are 0.
- R11: Reads accepted on rises t and t+2 produce four back-to-back output cycles with `rq_oe_o` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock; commands and beats are taken on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_sel_ni | input | 1 | Active-low read select |
| wr_sel_ni | input | 1 | Active-low write select |
| addr_i | input | AW | Burst base address (group of four words) |
| wd_rise_i | input | W | Write beat taken on the rising edge |
| wd_fall_i | input | W | Write beat of the complementary edge |
| wbe_rise_ni | input | 2 | Active-low byte writes for the rise beat |
| wbe_fall_ni | input | 2 | Active-low byte writes for the fall beat |
| rq_rise_o | output | W | Read beat for the rising edge (even position) |
| rq_fall_o | output | W | Read beat for the complementary edge (odd position) |
| rq_oe_o | output | 1 | Output enable; low means the read bus is released |

## Verification
The array is first filled with burst-unique patterns and read back across every address. A read returning the wrong group, a swapped lane or a misordered half shows up directly as a mismatch. Per-beat byte-write mixes (all, low only, high only, none) separate a lane swap in the mask from a dropped merge. Chains of two and three consecutive reads or writes separate a missing filter from one that blocks too long. Read and write issued on the same rise, and a read one rise after a write, pin down which beats a read may see.

// File: rtl/sio_burst4_pkg.sv
package sio_burst4_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned POS_W     = 2;
  localparam int unsigned LANES     = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } rd_phase_e;
endpackage

// File: rtl/sio_cmd_filter.sv
module sio_cmd_filter #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_sel_ni,
  input  logic          wr_sel_ni,
  input  logic [AW-1:0] addr_i,
  output logic          rd_first_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_lo_o,
  output logic          wr_hi_o,
  output logic [AW-1:0] wr_addr_o
);
  logic          rd_p1_q, wr_p1_q, wr_p2_q;
  logic [AW-1:0] rd_a_q, wr_a1_q, wr_a2_q;
  logic          rd_acc, wr_acc;

  // a select low right after an accepted command of its kind is dropped
  assign rd_acc = ~rd_sel_ni & ~rd_p1_q;
  assign wr_acc = ~wr_sel_ni & ~wr_p1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_p1_q <= 1'b0;
      wr_p1_q <= 1'b0;
      wr_p2_q <= 1'b0;
      rd_a_q  <= '0;
      wr_a1_q <= '0;
      wr_a2_q <= '0;
    end else begin
      rd_p1_q <= rd_acc;
      wr_p1_q <= wr_acc;
      wr_p2_q <= wr_p1_q;
      wr_a2_q <= wr_a1_q;
      if (rd_acc) rd_a_q  <= addr_i;
      if (wr_acc) wr_a1_q <= addr_i;
    end
  end

  assign rd_first_o = rd_p1_q;
  assign rd_addr_o  = rd_a_q;
  assign wr_lo_o    = wr_p1_q;
  assign wr_hi_o    = wr_p2_q;
  assign wr_addr_o  = wr_p1_q ? wr_a1_q : wr_a2_q;

  // R7
  rd_no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_first_o |=> !rd_first_o);
  // R8
  wr_no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |-> !wr_hi_o);
endmodule

// File: rtl/sio_sram_bank.sv
module sio_sram_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned W  = 18
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [1:0]    wbe_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned LANE_W = W / 2;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (!wbe_ni[0]) mem_q[waddr_i][LANE_W-1:0] <= wdata_i[LANE_W-1:0];
      if (!wbe_ni[1]) mem_q[waddr_i][W-1:LANE_W] <= wdata_i[W-1:LANE_W];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sio_rd_stage.sv
module sio_rd_stage
  import sio_burst4_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_first_i,
  input  logic [BURST_LEN-1:0][W-1:0] rd_words_i,
  output logic [W-1:0]                rq_rise_o,
  output logic [W-1:0]                rq_fall_o,
  output logic                        rq_oe_o
);
  rd_phase_e    phase_q;
  logic [W-1:0] hold_r_q, hold_f_q, q_r_q, q_f_q;

  // all four words are snapshotted on the first rise of the burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      hold_r_q <= '0;
      hold_f_q <= '0;
      q_r_q    <= '0;
      q_f_q    <= '0;
    end else if (rd_first_i) begin
      phase_q  <= PH_LO;
      q_r_q    <= rd_words_i[0];
      q_f_q    <= rd_words_i[1];
      hold_r_q <= rd_words_i[2];
      hold_f_q <= rd_words_i[3];
    end else if (phase_q == PH_LO) begin
      phase_q <= PH_HI;
      q_r_q   <= hold_r_q;
      q_f_q   <= hold_f_q;
    end else begin
      phase_q <= PH_IDLE;
      q_r_q   <= '0;
      q_f_q   <= '0;
    end
  end

  assign rq_rise_o = q_r_q;
  assign rq_fall_o = q_f_q;
  assign rq_oe_o   = (phase_q != PH_IDLE);

  // R10
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rq_oe_o |-> (rq_rise_o == '0 && rq_fall_o == '0));
  // R7
  no_restart_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_first_i |-> phase_q != PH_LO);
endmodule

// File: rtl/sio_burst4_sram.sv
module sio_burst4_sram
  import sio_burst4_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned W  = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_sel_ni,
  input  logic          wr_sel_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wd_rise_i,
  input  logic [W-1:0]  wd_fall_i,
  input  logic [1:0]    wbe_rise_ni,
  input  logic [1:0]    wbe_fall_ni,
  output logic [W-1:0]  rq_rise_o,
  output logic [W-1:0]  rq_fall_o,
  output logic          rq_oe_o
);
  logic                        rd_first, wr_lo, wr_hi;
  logic [AW-1:0]               rd_addr, wr_addr;
  logic [BURST_LEN-1:0][W-1:0] rd_words;

  sio_cmd_filter #(.AW(AW)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_sel_ni  (rd_sel_ni),
    .wr_sel_ni  (wr_sel_ni),
    .addr_i     (addr_i),
    .rd_first_o (rd_first),
    .rd_addr_o  (rd_addr),
    .wr_lo_o    (wr_lo),
    .wr_hi_o    (wr_hi),
    .wr_addr_o  (wr_addr)
  );

  // one bank per burst position: positions 0/1 on the first data rise, 2/3 on the second
  for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
    localparam bit ODD  = (b % 2) == 1;
    localparam bit HIGH = b >= (BURST_LEN / 2);
    sio_sram_bank #(.AW(AW), .W(W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (HIGH ? wr_hi : wr_lo),
      .waddr_i (wr_addr),
      .wdata_i (ODD ? wd_fall_i : wd_rise_i),
      .wbe_ni  (ODD ? wbe_fall_ni : wbe_rise_ni),
      .raddr_i (rd_addr),
      .rdata_o (rd_words[b])
    );
  end

  sio_rd_stage #(.W(W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_first_i (rd_first),
    .rd_words_i (rd_words),
    .rq_rise_o  (rq_rise_o),
    .rq_fall_o  (rq_fall_o),
    .rq_oe_o    (rq_oe_o)
  );

  // R3
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_sel_ni && !rd_first) |=> ##1 rq_oe_o);
  // R11
  rd_second_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rq_oe_o) |=> rq_oe_o);
endmodule

// File: tb/sio_burst4_sram_bench.sv
module sio_burst4_sram_bench;
  localparam int AW = 4;
  localparam int W  = 18;
  localparam int NW = (1 << AW) * 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_sel_ni = 1'b1, wr_sel_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0]  wd_rise_i = '0, wd_fall_i = '0;
  logic [1:0]    wbe_rise_ni = 2'b11, wbe_fall_ni = 2'b11;
  logic [W-1:0]  rq_rise_o, rq_fall_o;
  logic          rq_oe_o;

  always #10 clk_i = ~clk_i;

  sio_burst4_sram #(.AW(AW), .W(W)) u_sio_burst4_sram (.*);

  typedef struct { logic [W-1:0] r; logic [W-1:0] f; string tag; } item_t;
  item_t exp_q[$];

  int total = 0, bad = 0;
  bit mon_on = 0;
  string cur_req = "R3";

  logic [W-1:0]  mdl [NW];
  bit            b_rd_p1 = 0, b_wr_p1 = 0, b_wr_p2 = 0;
  logic [AW-1:0] b_rd_a = '0, b_wr_a = '0, b_wr_a2 = '0;

  task automatic chk(string r, logic [2*W:0] act, logic [2*W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic mwrite(int idx, logic [W-1:0] d, logic [1:0] bn);
    if (!bn[0]) mdl[idx][8:0]  = d[8:0];
    if (!bn[1]) mdl[idx][17:9] = d[17:9];
  endtask

  // driver: model of the requirements, run before the edge the inputs apply to
  task automatic step(bit rdn, bit wrn, logic [AW-1:0] a,
                      logic [W-1:0] dr, logic [W-1:0] df,
                      logic [1:0] br, logic [1:0] bf);
    item_t it;
    bit acc;
    @(negedge clk_i);
    if (b_rd_p1) begin  // R9: snapshot before this rise's writes
      it.tag = cur_req;
      it.r = mdl[{b_rd_a, 2'd0}]; it.f = mdl[{b_rd_a, 2'd1}]; exp_q.push_back(it);
      it.r = mdl[{b_rd_a, 2'd2}]; it.f = mdl[{b_rd_a, 2'd3}]; exp_q.push_back(it);
    end
    if (b_wr_p1) begin mwrite({b_wr_a, 2'd0}, dr, br); mwrite({b_wr_a, 2'd1}, df, bf); end
    if (b_wr_p2) begin mwrite({b_wr_a2, 2'd2}, dr, br); mwrite({b_wr_a2, 2'd3}, df, bf); end
    b_wr_a2 = b_wr_a;
    b_wr_p2 = b_wr_p1;
    acc = !wrn && !b_wr_p1;
    b_wr_p1 = acc;
    if (acc) b_wr_a = a;
    acc = !rdn && !b_rd_p1;
    b_rd_p1 = acc;
    if (acc) b_rd_a = a;
    rd_sel_ni = rdn; wr_sel_ni = wrn; addr_i = a;
    wd_rise_i = dr; wd_fall_i = df; wbe_rise_ni = br; wbe_fall_ni = bf;
  endtask

  task automatic nop(); step(1, 1, '0, '0, '0, 2'b11, 2'b11); endtask

  task automatic wr_burst(logic [AW-1:0] a, logic [W-1:0] w0, w1, w2, w3,
                          logic [1:0] m0, m1, m2, m3);
    step(1, 0, a, '0, '0, 2'b11, 2'b11);
    step(1, 1, '0, w0, w1, m0, m1);
    step(1, 1, '0, w2, w3, m2, m3);
  endtask

  task automatic rd_burst(logic [AW-1:0] a);
    step(0, 1, a, '0, '0, 2'b11, 2'b11);
    nop(); nop();
  endtask

  // monitor: pops expected beats, otherwise expects a released bus
  always @(posedge clk_i) begin
    #5;
    if (mon_on) begin
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, {rq_oe_o, rq_rise_o, rq_fall_o}, {1'b1, it.r, it.f});
      end else begin
        chk("R2 R10", {rq_oe_o, rq_rise_o, rq_fall_o}, '0);
      end
    end
  end

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [W-1:0] pat(int a, int p);
    return W'((a * 4 + p) * 1031 + 18'h15a5);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", {rq_oe_o, rq_rise_o, rq_fall_o}, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #5;
    chk("R1", {rq_oe_o, rq_rise_o, rq_fall_o}, '0);
    mon_on = 1;

    // R4: fill every group
    for (int a = 0; a < (1 << AW); a++)
      wr_burst(AW'(a), pat(a, 0), pat(a, 1), pat(a, 2), pat(a, 3),
               2'b00, 2'b00, 2'b00, 2'b00);
    // R3 R5: read back every group
    cur_req = "R3 R5";
    for (int a = 0; a < (1 << AW); a++) rd_burst(AW'(a));

    // R2: idle rises with garbage on the lanes change nothing
    for (int i = 0; i < 4; i++) step(1, 1, AW'(i), 18'h3ffff, 18'h3ffff, 2'b00, 2'b00);
    cur_req = "R2";
    rd_burst(4'd2);

    // R6: per-beat byte masks
    wr_burst(4'd5, 18'h3aaaa, 18'h15555, 18'h0f0f0, 18'h30303,
             2'b00, 2'b10, 2'b01, 2'b11);
    cur_req = "R6";
    rd_burst(4'd5);

    // R7 R11: read, ignored read, accepted read -> continuous output
    cur_req = "R7 R11";
    step(0, 1, 4'd1, '0, '0, 2'b11, 2'b11);
    step(0, 1, 4'd9, '0, '0, 2'b11, 2'b11);
    step(0, 1, 4'd7, '0, '0, 2'b11, 2'b11);
    nop(); nop(); nop();

    // R8: back-to-back write, second dropped
    step(1, 0, 4'd3, '0, '0, 2'b11, 2'b11);
    step(1, 0, 4'd12, 18'h00111, 18'h00222, 2'b00, 2'b00);
    step(1, 1, '0, 18'h00333, 18'h00444, 2'b00, 2'b00);
    nop();
    cur_req = "R8";
    rd_burst(4'd12);
    rd_burst(4'd3);

    // R9: read and write on the same rise see old data; read after write sees half
    cur_req = "R9";
    step(0, 0, 4'd6, '0, '0, 2'b11, 2'b11);
    step(1, 1, '0, 18'h2bbbb, 18'h2cccc, 2'b00, 2'b00);
    step(1, 1, '0, 18'h2dddd, 18'h2eeee, 2'b00, 2'b00);
    rd_burst(4'd6);
    step(1, 0, 4'd8, '0, '0, 2'b11, 2'b11);
    step(0, 1, 4'd8, 18'h01234, 18'h05678, 2'b00, 2'b00);
    step(1, 1, '0, 18'h09abc, 18'h0def0, 2'b00, 2'b00);
    nop();
    rd_burst(4'd8);

    repeat (4) nop();
    chk("R3", 37'(exp_q.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule